// File: doc/BRIEF.md
# Shadow RAM Bus Decoder

This block is the address-decode glue between a processor with an 8-bit data bus and a 20-bit address, its motherboard memory, and a 512 KB external static RAM. It places the static RAM in four windows of the memory map. The first window covers the lower 64 KB of motherboard RAM, which also holds the picture memory. That window is a write-through shadow. Writes land in both memories, so the picture stays correct. Reads are served from the fast static RAM alone. The second window fully replaces the upper 64 KB of motherboard RAM. The third window adds 256 KB of RAM directly above, which gives 384 KB of contiguous RAM from $20000. The fourth window is a 128 KB battery-backed page at the top of the map. Writes to that page are gated by an external latch bit.

For each cycle the decoder sets the static RAM chip select, write enable and address. It also drives a motherboard-disable line, active high, and a zero-wait acknowledge, active low. The motherboard-disable line depends only on the address and the direction, so it is valid before the data strobe becomes active. Chip select, write enable and acknowledge follow the strobe. An enable switch can remove both upper windows so that an expansion card can use that space. The switch passes through a two-flop synchronizer. The reset is asynchronous on assertion and synchronous on release.

Top module: `shadow_ram_decoder`

## Requirements
- R1: For an address in $30000–$3FFFF, for reads and writes alike, mb_disable is 1. While cpu_ds_n is 0, sram_cs_n and dtack_n are 0. sram_addr equals the address minus $20000, giving $10000–$1FFFF.
- R2: For a read (cpu_rd=1) in $20000–$2FFFF, mb_disable is 1 and sram_addr is the address minus $20000. While the strobe is active, sram_cs_n and dtack_n are 0.
- R3: For a write (cpu_rd=0) in $20000–$2FFFF with the strobe active, sram_cs_n and sram_we_n are 0. mb_disable stays 0 and dtack_n stays 1, so the motherboard ends the cycle.
- R4: With the expansion enabled, an address in $40000–$7FFFF maps to sram_addr = address − $20000 ($20000–$5FFFF). With the strobe active it gets chip select and dtack_n=0, and a write also gets sram_we_n=0. mb_disable stays 0.
- R5: With the expansion enabled, an address in $E0000–$FFFFF maps to sram_addr = address − $80000 ($60000–$7FFFF). A read with the strobe active gets chip select and dtack_n=0.
- R6: A write to $E0000–$FFFFF with the strobe active sets sram_we_n to 0 only when nv_wr_allow is 1. When nv_wr_allow is 0, sram_we_n stays 1 while chip select and dtack_n=0 are still given.
- R7: exp_switch takes effect after two rising clock edges and is seen as off from reset. While it is seen as off, addresses of $40000 and above drive no chip select, no write enable and no acknowledge.
- R8: mb_disable never depends on cpu_ds_n. For a fixed address and direction it has the same value with the strobe inactive and active.
- R9: While cpu_ds_n is 1, sram_cs_n, sram_we_n and dtack_n are all 1.
- R10: A read cycle never drives sram_we_n to 0.
- R11: Addresses outside every window (below $20000 and $80000–$DFFFF) give no select, no write enable, no acknowledge, mb_disable=0 and sram_addr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 20 | Processor address |
| cpu_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| cpu_ds_n | input | 1 | Data strobe, active low |
| nv_wr_allow | input | 1 | Write-permit latch bit for the battery-backed page |
| exp_switch | input | 1 | Enable switch for the upper windows (asynchronous) |
| sram_cs_n | output | 1 | Static RAM chip select, active low |
| sram_we_n | output | 1 | Static RAM write enable, active low |
| sram_addr | output | 19 | Static RAM address |
| mb_disable | output | 1 | Motherboard decode disable, active high |
| dtack_n | output | 1 | Zero-wait acknowledge, active low |

## Verification
The bench targets the direction split inside the video window. A design that acknowledged shadow writes would end the cycle before the motherboard RAM was written, and one that left the motherboard enabled on shadow reads would have two drivers on the data bus. It probes the exact edges of every window, $1FFFF/$20000, $7FFFF/$80000 and $DFFFF/$E0000, where an off-by-one compare would select the wrong memory or fold the top page onto the extra RAM. Blocked writes to the battery-backed page are checked to be acknowledged without a write enable, since a wrong gate would either hang the bus or corrupt stored data. The switch is toggled and sampled one edge and two edges later, to catch a missing or extra synchronizer stage.

// File: rtl/shadow_dec_pkg.sv
package shadow_dec_pkg;
  typedef enum logic [2:0] {
    RG_NONE   = 3'd0,
    RG_VIDEO  = 3'd1,
    RG_REPL   = 3'd2,
    RG_EXTRA  = 3'd3,
    RG_NVPAGE = 3'd4
  } region_e;
endpackage

// File: rtl/sdec_sync.sv
module sdec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_comb chain_d[i] = d;
      end else begin : g_next
        always_comb chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sdec_region.sv
module sdec_region
  import shadow_dec_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter logic [19:0] VID_BASE   = 20'h20000,
  parameter logic [19:0] WIN_SIZE   = 20'h10000,
  parameter logic [19:0] EXTRA_BASE = 20'h40000,
  parameter logic [19:0] EXTRA_SIZE = 20'h40000,
  parameter logic [19:0] NV_BASE    = 20'hE0000,
  parameter logic [19:0] NV_SIZE    = 20'h20000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              exp_on,
  output region_e           region
);
  localparam logic [ADDR_W:0] VID_LO   = ADDR_W'(VID_BASE);
  localparam logic [ADDR_W:0] REPL_LO  = VID_LO + ADDR_W'(WIN_SIZE);
  localparam logic [ADDR_W:0] REPL_END = REPL_LO + ADDR_W'(WIN_SIZE);
  localparam logic [ADDR_W:0] EXT_LO   = ADDR_W'(EXTRA_BASE);
  localparam logic [ADDR_W:0] EXT_END  = EXT_LO + ADDR_W'(EXTRA_SIZE);
  localparam logic [ADDR_W:0] NV_LO    = ADDR_W'(NV_BASE);
  localparam logic [ADDR_W:0] NV_END   = NV_LO + ADDR_W'(NV_SIZE);

  logic [ADDR_W:0] a_ext;
  assign a_ext = {1'b0, addr};

  always_comb begin
    region = RG_NONE;
    if (a_ext >= VID_LO && a_ext < REPL_LO)
      region = RG_VIDEO;
    else if (a_ext >= REPL_LO && a_ext < REPL_END)
      region = RG_REPL;
    else if (exp_on && a_ext >= EXT_LO && a_ext < EXT_END)
      region = RG_EXTRA;
    else if (exp_on && a_ext >= NV_LO && a_ext < NV_END)
      region = RG_NVPAGE;
  end
endmodule

// File: rtl/sdec_remap.sv
module sdec_remap
  import shadow_dec_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter int          SRAM_W     = 19,
  parameter logic [19:0] VID_BASE   = 20'h20000,
  parameter logic [19:0] EXTRA_BASE = 20'h40000,
  parameter logic [19:0] NV_BASE    = 20'hE0000,
  parameter logic [18:0] EXTRA_SRAM = 19'h20000,
  parameter logic [18:0] NV_SRAM    = 19'h60000
) (
  input  logic [ADDR_W-1:0] addr,
  input  region_e           region,
  output logic [SRAM_W-1:0] sram_addr
);
  logic [ADDR_W-1:0] base;
  logic [SRAM_W-1:0] sbase;
  logic [ADDR_W-1:0] offs;

  always_comb begin
    base  = ADDR_W'(VID_BASE);
    sbase = '0;
    unique case (region)
      RG_EXTRA: begin
        base  = ADDR_W'(EXTRA_BASE);
        sbase = SRAM_W'(EXTRA_SRAM);
      end
      RG_NVPAGE: begin
        base  = ADDR_W'(NV_BASE);
        sbase = SRAM_W'(NV_SRAM);
      end
      default: ;
    endcase
    offs      = addr - base;
    sram_addr = (region == RG_NONE) ? '0 : sbase + offs[SRAM_W-1:0];
  end
endmodule

// File: rtl/sdec_strobe.sv
module sdec_strobe
  import shadow_dec_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  region_e region,
  input  logic    rd,
  input  logic    ds_n,
  input  logic    nv_wen,
  output logic    mb_off,
  output logic    cs_n,
  output logic    we_n,
  output logic    dtack_n
);
  logic hit, active, own_cycle, wr_ok;

  always_comb begin
    hit       = (region != RG_NONE);
    active    = !ds_n;
    mb_off    = (region == RG_REPL) || (region == RG_VIDEO && rd);
    own_cycle = mb_off || region == RG_EXTRA || region == RG_NVPAGE;
    wr_ok     = (region != RG_NVPAGE) || nv_wen;
    cs_n      = !(hit && active);
    we_n      = !(hit && active && !rd && wr_ok);
    dtack_n   = !(active && own_cycle);
  end

  // R9: strobe inactive leaves every cycle output idle
  p_idle_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ds_n |-> (cs_n && we_n && dtack_n));

  // R10: reads never write-enable the static RAM
  p_read_no_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> we_n);

  // R3: shadow write leaves termination to the motherboard
  p_video_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_VIDEO && !rd && !ds_n) |-> (!we_n && dtack_n && !mb_off));

  // R2: shadow read is served locally
  p_video_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_VIDEO && rd && !ds_n) |-> (!cs_n && !dtack_n && mb_off));

  // R6: blocked write to the protected page still acknowledged
  p_nv_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_NVPAGE && !rd && !ds_n && !nv_wen) |-> (we_n && !dtack_n));
endmodule

// File: rtl/shadow_ram_decoder.sv
module shadow_ram_decoder
  import shadow_dec_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int SRAM_W      = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_ds_n,
  input  logic              nv_wr_allow,
  input  logic              exp_switch,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic [SRAM_W-1:0] sram_addr,
  output logic              mb_disable,
  output logic              dtack_n
);
  localparam logic [ADDR_W-1:0] EXT_FLOOR = ADDR_W'(20'h40000);

  logic    rst_sync_n;
  logic    exp_on_s;
  region_e region;

  sdec_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  sdec_sync #(.STAGES(SYNC_STAGES)) u_exp_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(exp_switch), .q(exp_on_s)
  );

  sdec_region #(.ADDR_W(ADDR_W)) u_region (
    .addr(cpu_addr), .exp_on(exp_on_s), .region(region)
  );

  sdec_remap #(.ADDR_W(ADDR_W), .SRAM_W(SRAM_W)) u_remap (
    .addr(cpu_addr), .region(region), .sram_addr(sram_addr)
  );

  sdec_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .region(region), .rd(cpu_rd),
    .ds_n(cpu_ds_n), .nv_wen(nv_wr_allow), .mb_off(mb_disable),
    .cs_n(sram_cs_n), .we_n(sram_we_n), .dtack_n(dtack_n)
  );

  // R7: with the switch seen as off, no upper window answers
  p_ext_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!exp_on_s && cpu_addr >= EXT_FLOOR) |-> (sram_cs_n && dtack_n && sram_we_n));

  // R8: motherboard disable is steady across a strobe change
  p_mb_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cpu_addr) && $stable(cpu_rd)) |-> $stable(mb_disable));
endmodule

// File: tb/sim_shadow_ram_decoder.sv
module sim_shadow_ram_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic        rd = 1'b1, ds_n = 1'b1, nvw = 1'b0, sw = 1'b0;
  logic        cs_n, we_n, mb, dt_n;
  logic [18:0] saddr;
  logic        en_model = 1'b0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  shadow_ram_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cpu_rd(rd), .cpu_ds_n(ds_n),
    .nv_wr_allow(nvw), .exp_switch(sw), .sram_cs_n(cs_n), .sram_we_n(we_n),
    .sram_addr(saddr), .mb_disable(mb), .dtack_n(dt_n)
  );

  // expected {mb, cs_n, we_n, dtack_n, saddr}
  function automatic logic [22:0] model(logic [19:0] a, logic r, logic d_n,
                                        logic nv_ok, logic en);
    logic vid, rep, ext, nvp, hit, act;
    logic [19:0] sa;
    vid = a >= 20'h20000 && a <= 20'h2FFFF;
    rep = a >= 20'h30000 && a <= 20'h3FFFF;
    ext = en && a >= 20'h40000 && a <= 20'h7FFFF;
    nvp = en && a >= 20'hE0000;
    hit = vid | rep | ext | nvp;
    act = !d_n;
    sa  = nvp ? a - 20'h80000 : (hit ? a - 20'h20000 : 20'h0);
    return {rep | (vid & r), !(hit & act), !(hit & act & !r & (!nvp | nv_ok)),
            !(act & (rep | (vid & r) | ext | nvp)), sa[18:0]};
  endfunction

  function automatic string tag_of(logic [19:0] a, logic r, logic d_n, logic en);
    if (d_n) return "R9";
    if (a >= 20'h20000 && a <= 20'h2FFFF) return r ? "R2" : "R3";
    if (a >= 20'h30000 && a <= 20'h3FFFF) return "R1";
    if (!en && a >= 20'h40000) return "R7";
    if (a >= 20'h40000 && a <= 20'h7FFFF) return "R4";
    if (a >= 20'hE0000) return r ? "R5" : "R6";
    return "R11";
  endfunction

  task automatic compare(string tag);
    logic [22:0] exp_v, got;
    exp_v = model(addr, rd, ds_n, nvw, en_model);
    got   = {mb, cs_n, we_n, dt_n, saddr};
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s addr=%h rd=%b ds_n=%b: got %h expected %h",
               tag, addr, rd, ds_n, got, exp_v);
    end
  endtask

  task automatic drive(logic [19:0] a, logic r, logic d_n, logic nv_ok);
    @(negedge clk);
    addr = a; rd = r; ds_n = d_n; nvw = nv_ok;
    #2;
  endtask

  task automatic set_switch(logic v);
    @(negedge clk);
    sw = v;
    @(posedge clk); @(posedge clk);
    en_model = v;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic mb_idle;
    // reset state: upper windows off, strobe idle
    addr = 20'h40000; rd = 1'b1; ds_n = 1'b0; sw = 1'b1;
    #22;
    compare("R7 reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    en_model = 1'b1;
    // directed window edges
    drive(20'h1FFFF, 1, 0, 0); compare("R11");
    drive(20'h20000, 1, 0, 0); compare("R2");
    drive(20'h2FFFF, 0, 0, 0); compare("R3");
    drive(20'h30000, 0, 0, 0); compare("R1");
    drive(20'h3FFFF, 1, 0, 0); compare("R1");
    drive(20'h40000, 0, 0, 0); compare("R4");
    drive(20'h7FFFF, 1, 0, 0); compare("R4");
    drive(20'h80000, 1, 0, 0); compare("R11");
    drive(20'hDFFFF, 0, 0, 1); compare("R11");
    drive(20'hE0000, 1, 0, 0); compare("R5");
    drive(20'hFFFFF, 0, 0, 0); compare("R6 blocked");
    drive(20'hFFFFF, 0, 0, 1); compare("R6 allowed");
    drive(20'h2ABCD, 1, 1, 0); compare("R9");
    drive(20'h55555, 1, 0, 0); compare("R10");
    // R8: mb_disable identical across strobe
    drive(20'h24321, 1, 1, 0); mb_idle = mb;
    drive(20'h24321, 1, 0, 0);
    checks++;
    if (mb !== mb_idle || mb !== 1'b1) begin
      errors++;
      $display("FAIL R8: got %b/%b expected 1/1", mb_idle, mb);
    end
    // R7: switch off takes two edges
    drive(20'h60000, 1, 0, 0);
    @(negedge clk); sw = 1'b0;
    @(posedge clk); #2;
    compare("R7 one edge");
    @(posedge clk); #2;
    en_model = 1'b0;
    compare("R7 two edges");
    drive(20'hE1234, 0, 0, 1); compare("R7");
    // random traffic
    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      logic [19:0] a;
      logic [2:0] pick;
      if (i % 150 == 75) set_switch(!en_model);
      pick = 3'($urandom_range(0, 5));
      a = 20'($urandom);
      case (pick)
        3'd0: a = 20'h20000 | (a & 20'h0FFFF);
        3'd1: a = 20'h30000 | (a & 20'h0FFFF);
        3'd2: a = 20'h40000 | (a & 20'h3FFFF);
        3'd3: a = 20'hE0000 | (a & 20'h1FFFF);
        default: ;
      endcase
      drive(a, 1'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom));
      compare(tag_of(addr, rd, ds_n, en_model));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule